// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A free-running counter spans one switching period. Its length in system clocks comes from a period register. Each of the three phases has an on-time register. The block places one low pulse per phase symmetrically about the middle of the period, and a complementary low pulse outside a slightly wider window. The gap between the two windows is the programmable deadtime, so the two switches of a leg are never on together.

A host loads the registers through a single-cycle write port. Duty changes are staged. They reach the outputs only after all three phase registers have been written, and only at a period boundary. This prevents a half-updated vector from being driven. Pulses narrower than a programmable minimum are suppressed. A one-clock sync pulse marks each period start, and a stop input forces every output to its inactive (high) level.

Top module: `pwm3_centre`

## Requirements
- R1: While reset is applied, and after reset until the first complete set of phase values has been latched, all six outputs are high and `sync_o` is low during reset.
- R2: The write address 0 sets the period P, in clocks. From the next period start, `sync_o` is high for exactly one clock every max(P,2) clocks.
- R3: The phase on-times are at addresses 1, 2 and 3. They take effect at the first period start after each of the three has been written at least once since the last latch, the last write landing at least one clock before that start. Writing only some of them changes nothing.
- R4: The output phase φ counts clocks from 0 in the cycle where `sync_o` is high. With on-time D, deadtime T and width W1 = min(max(D−T,0),P), the main output `hi_n_o[c]` is low exactly for φ in [(P−W1)>>1, (P−W1)>>1 + W1).
- R5: The deadtime is written at address 4 (data bits 6:0) with bit 0 ignored, so T is even and lies between 0 and 126. With W2 = min(D+T,P), the complementary output `lo_n_o[c]` is high exactly for φ in [(P−W2)>>1, (P−W2)>>1 + W2) and low elsewhere.
- R6: The minimum width M is written at address 5 (data bits 6:0). If W1 < M, the main output of that phase stays high for the whole period and its complement stays low for the whole period.
- R7: For no phase are `hi_n_o[c]` and `lo_n_o[c]` low in the same cycle.
- R8: When `stop_i` is sampled high at a clock edge, all six outputs are high from that edge on. Normal output resumes at the edge after it is sampled low.
- R9: Period, deadtime and minimum-width writes take effect at the next period start, independently of the phase-register latch.
- R10: Writes to addresses 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 12 | Write data |
| stop_i | input | 1 | Shutdown, high forces all outputs high |
| sync_o | output | 1 | One-clock pulse at each period start |
| hi_n_o | output | 3 | Main outputs per phase, active low |
| lo_n_o | output | 3 | Complementary outputs per phase, active low |

## Verification
A behavioural model in the bench tracks the register staging and the period counter, and is compared with every output on every clock. It is driven with a series of patterns, and each pattern separates a different fault:
- A partial set of phase writes separates the staged latch from immediate update.
- Mid-range, zero, full and over-range on-times with and without deadtime show the centring arithmetic and the clamps.
- An odd period and an odd deadtime write show the rounding of the window start and the dropped low bit.
- A minimum width between the two pulse widths shows that deletion acts per phase.
- Stop pulses in mid-period and writes to the unused addresses complete the set.

Hand-counted pulse widths over one period cross-check the model.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CW  = 12;
  localparam int DW  = 7;
  localparam int AW  = 3;
  localparam int NCH = 3;

  localparam logic [AW-1:0] ADDR_PERIOD  = 3'd0;
  localparam logic [AW-1:0] ADDR_CH_BASE = 3'd1;
  localparam logic [AW-1:0] ADDR_DEAD    = 3'd4;
  localparam logic [AW-1:0] ADDR_MINW    = 3'd5;

  typedef struct packed {
    logic [CW:0] main_s;
    logic [CW:0] main_e;
    logic [CW:0] comp_s;
    logic [CW:0] comp_e;
  } win_t;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter logic [CW-1:0] DEF_PERIOD = 12'd1250
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [CW-1:0]           wr_data_i,
  input  logic                    wrap_i,
  output logic [CW-1:0]           per_act_o,
  output logic [NCH-1:0][CW-1:0]  duty_act_o,
  output logic [DW-1:0]           dt_act_o,
  output logic [DW-1:0]           minw_act_o,
  output logic                    armed_o
);
  localparam logic [CW-1:0] PMIN = CW'(2);

  function automatic logic [CW-1:0] clamp_p(input logic [CW-1:0] v);
    return (v < PMIN) ? PMIN : v;
  endfunction

  logic [CW-1:0]          per_q;
  logic [DW-1:0]          dt_q;
  logic [DW-1:0]          minw_q;
  logic [NCH-1:0][CW-1:0] duty_q;
  logic [NCH-1:0]         flag_q;
  logic [NCH-1:0]         ch_wr;
  logic                   all_set;

  assign all_set = &flag_q;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign ch_wr[g] = wr_en_i && (wr_addr_i == ADDR_CH_BASE + AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q      <= DEF_PERIOD;
      dt_q       <= '0;
      minw_q     <= '0;
      per_act_o  <= clamp_p(DEF_PERIOD);
      dt_act_o   <= '0;
      minw_act_o <= '0;
      armed_o    <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_PERIOD) per_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_DEAD)   dt_q   <= {wr_data_i[DW-1:1], 1'b0};
      if (wr_en_i && wr_addr_i == ADDR_MINW)   minw_q <= wr_data_i[DW-1:0];
      if (wrap_i) begin
        per_act_o  <= clamp_p(per_q);
        dt_act_o   <= dt_q;
        minw_act_o <= minw_q;
        if (all_set) armed_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q     <= '0;
      flag_q     <= '0;
      duty_act_o <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_wr[c]) begin
          duty_q[c] <= wr_data_i;
          flag_q[c] <= 1'b1;
        end else if (wrap_i && all_set) begin
          flag_q[c] <= 1'b0;
        end
        if (wrap_i && all_set) duty_act_o[c] <= duty_q[c];
      end
    end
  end

  // R3: a complete staged set arms the outputs at the boundary
  assert_latch_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && all_set) |=> armed_o);

  // R9: active period never drops below the floor
  assert_period_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (per_act_o >= PMIN));
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] per_act_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          sync_o
);
  logic [CW-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_act_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else begin
      cnt_q  <= wrap_o ? '0 : cnt_q + 1'b1;
      sync_o <= (cnt_q == '0);
    end
  end

  assert_cnt_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_act_i);

  assert_sync_one_clock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
endmodule

// File: rtl/pwm3_edge_calc.sv
module pwm3_edge_calc
  import pwm3_pkg::*;
(
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] duty_i,
  input  logic [DW-1:0] dt_i,
  input  logic [DW-1:0] minw_i,
  output win_t          win_o
);
  logic [CW:0] p, d, t, m;
  logic [CW:0] w1, w2;

  always_comb begin
    p  = {1'b0, per_i};
    d  = {1'b0, duty_i};
    t  = (CW+1)'(dt_i);
    m  = (CW+1)'(minw_i);
    w1 = (d > t) ? d - t : '0;
    if (w1 > p) w1 = p;
    w2 = d + t;
    if (w2 > p) w2 = p;
    // deletion: main off, complement on for the whole period
    if (w1 < m) begin
      w1 = '0;
      w2 = '0;
    end
    win_o.main_s = (p - w1) >> 1;
    win_o.main_e = ((p - w1) >> 1) + w1;
    win_o.comp_s = (p - w2) >> 1;
    win_o.comp_e = ((p - w2) >> 1) + w2;
  end
endmodule

// File: rtl/pwm3_out_stage.sv
module pwm3_out_stage
  import pwm3_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  cnt_i,
  input  win_t           win_i [NCH],
  input  logic           armed_i,
  input  logic           stop_i,
  output logic [NCH-1:0] hi_n_o,
  output logic [NCH-1:0] lo_n_o
);
  logic [CW:0]    c;
  logic [NCH-1:0] main_on, comp_on;
  logic           run;

  assign c   = {1'b0, cnt_i};
  assign run = armed_i && !stop_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign main_on[g] = (c >= win_i[g].main_s) && (c < win_i[g].main_e);
    assign comp_on[g] = !((c >= win_i[g].comp_s) && (c < win_i[g].comp_e));

    assert_no_shoot_through_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_n_o[g] || lo_n_o[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_n_o <= '1;
      lo_n_o <= '1;
    end else begin
      hi_n_o <= ~(main_on & {NCH{run}});
      lo_n_o <= ~(comp_on & {NCH{run}});
    end
  end

  assert_stop_forces_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (&hi_n_o && &lo_n_o));

  assert_idle_until_armed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (&hi_n_o && &lo_n_o));
endmodule

// File: rtl/pwm3_centre.sv
module pwm3_centre
  import pwm3_pkg::*;
#(
  parameter logic [CW-1:0] DEF_PERIOD = 12'd1250
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [CW-1:0]  wr_data_i,
  input  logic           stop_i,
  output logic           sync_o,
  output logic [NCH-1:0] hi_n_o,
  output logic [NCH-1:0] lo_n_o
);
  logic [CW-1:0]          per_act;
  logic [NCH-1:0][CW-1:0] duty_act;
  logic [DW-1:0]          dt_act, minw_act;
  logic                   armed, wrap;
  logic [CW-1:0]          cnt;
  win_t                   win [NCH];

  pwm3_regs #(.DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wrap_i     (wrap),
    .per_act_o  (per_act),
    .duty_act_o (duty_act),
    .dt_act_o   (dt_act),
    .minw_act_o (minw_act),
    .armed_o    (armed)
  );

  pwm3_timebase u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_act_i (per_act),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .sync_o    (sync_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_calc
    pwm3_edge_calc u_calc (
      .per_i  (per_act),
      .duty_i (duty_act[g]),
      .dt_i   (dt_act),
      .minw_i (minw_act),
      .win_o  (win[g])
    );
  end

  pwm3_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .win_i   (win),
    .armed_i (armed),
    .stop_i  (stop_i),
    .hi_n_o  (hi_n_o),
    .lo_n_o  (lo_n_o)
  );
endmodule

// File: tb/tb_pwm3_centre.sv
`timescale 1ns/1ps
module tb_pwm3_centre;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        stop = 1'b0;
  logic        sync;
  logic [2:0]  hi_n, lo_n;

  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwm3_centre #(.DEF_PERIOD(12'd40)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .stop_i(stop), .sync_o(sync), .hi_n_o(hi_n), .lo_n_o(lo_n)
  );

  // behavioural reference
  int m_per, m_dt, m_minw, m_pact, m_dtact, m_minwact, m_cnt;
  int m_duty[3], m_dact[3];
  bit m_flag[3];
  bit m_armed, m_sync;
  bit [2:0] m_hi, m_lo;

  function automatic void win(input int p, d, t, mw, output int s1, e1, s2, e2);
    int w1, w2;
    w1 = (d > t) ? d - t : 0;
    if (w1 > p) w1 = p;
    w2 = d + t;
    if (w2 > p) w2 = p;
    if (w1 < mw) begin w1 = 0; w2 = 0; end
    s1 = (p - w1) / 2; e1 = s1 + w1;
    s2 = (p - w2) / 2; e2 = s2 + w2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 40; m_dt = 0; m_minw = 0; m_pact = 40; m_dtact = 0; m_minwact = 0;
      m_cnt = 0; m_armed = 0; m_sync = 0; m_hi = '1; m_lo = '1;
      for (int i = 0; i < 3; i++) begin m_duty[i] = 0; m_dact[i] = 0; m_flag[i] = 0; end
    end else begin
      int s1, e1, s2, e2;
      bit all, wrap;
      for (int i = 0; i < 3; i++) begin
        win(m_pact, m_dact[i], m_dtact, m_minwact, s1, e1, s2, e2);
        m_hi[i] = !(m_armed && !stop && m_cnt >= s1 && m_cnt < e1);
        m_lo[i] = !(m_armed && !stop && !(m_cnt >= s2 && m_cnt < e2));
      end
      m_sync = (m_cnt == 0);
      all  = m_flag[0] && m_flag[1] && m_flag[2];
      wrap = (m_cnt >= m_pact - 1);
      if (wrap) begin
        m_cnt = 0;
        m_pact = (m_per < 2) ? 2 : m_per;
        m_dtact = m_dt; m_minwact = m_minw;
        if (all) begin
          m_armed = 1;
          for (int i = 0; i < 3; i++) begin m_dact[i] = m_duty[i]; m_flag[i] = 0; end
        end
      end else m_cnt = m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per = wr_data;
          3'd1, 3'd2, 3'd3: begin m_duty[wr_addr-1] = wr_data; m_flag[wr_addr-1] = 1; end
          3'd4: m_dt = wr_data[6:0] & 7'h7E;
          3'd5: m_minw = wr_data[6:0];
          default: ;
        endcase
      end
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        checks++;
        if (hi_n !== 3'b111 || lo_n !== 3'b111 || sync !== 1'b0) begin
          fails++;
          $display("FAIL R1 reset: hi=%b lo=%b sync=%b expected 111 111 0", hi_n, lo_n, sync);
        end
      end else begin
        checks++;
        if (sync !== m_sync) begin
          fails++;
          $display("FAIL R2 (%s) cyc %0d: sync=%b expected %b", tag, cyc, sync, m_sync);
        end
        checks++;
        if (hi_n !== m_hi || lo_n !== m_lo) begin
          fails++;
          $display("FAIL %s cyc %0d: hi=%b lo=%b expected hi=%b lo=%b", tag, cyc, hi_n, lo_n, m_hi, m_lo);
        end
        checks++;
        if (((~hi_n) & (~lo_n)) != 3'b000) begin
          fails++;
          $display("FAIL R7 cyc %0d: hi=%b lo=%b expected no leg with both low", cyc, hi_n, lo_n);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[11:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set3(input int a, input int b, input int c);
    wr(1, a); wr(2, b); wr(3, c);
  endtask

  // count low cycles of phase ch over one period starting at sync
  task automatic measure(input int ch, input int p, input int exp_m, input int exp_c, input string rq);
    int nm, nc;
    nm = 0; nc = 0;
    @(negedge clk);
    while (sync !== 1'b1) @(negedge clk);
    for (int i = 0; i < p; i++) begin
      if (hi_n[ch] === 1'b0) nm++;
      if (lo_n[ch] === 1'b0) nc++;
      @(negedge clk);
    end
    checks++;
    if (nm != exp_m || nc != exp_c) begin
      fails++;
      $display("FAIL %s width ch%0d: main_low=%0d comp_low=%0d expected %0d %0d", rq, ch, nm, nc, exp_m, exp_c);
    end
  endtask

  initial begin
    run(3);
    rst_n = 1;
    tag = "R1";
    run(50);
    tag = "R3";
    wr(1, 10); wr(2, 5);
    run(90);
    checks++;
    if (hi_n !== 3'b111 || lo_n !== 3'b111) begin
      fails++;
      $display("FAIL R3 partial: hi=%b lo=%b expected 111 111", hi_n, lo_n);
    end
    tag = "R2";
    wr(0, 20);
    wr(4, 4);
    run(60);
    tag = "R3";
    wr(3, 15);
    run(60);
    tag = "R4";
    wr(4, 0);
    set3(10, 0, 20);
    run(45);
    measure(0, 20, 10, 10, "R4");
    measure(2, 20, 20, 0, "R4");
    tag = "R5";
    wr(4, 5);
    set3(10, 3, 17);
    run(45);
    measure(0, 20, 6, 6, "R5");
    set3(25, 4095, 2);
    run(45);
    tag = "R6";
    wr(5, 8);
    set3(10, 14, 2);
    run(45);
    measure(0, 20, 0, 20, "R6");
    measure(1, 20, 10, 2, "R6");
    tag = "R9";
    wr(5, 0);
    wr(0, 21);
    run(50);
    wr(4, 126);
    set3(200, 25, 4095);
    run(50);
    wr(4, 2);
    set3(7, 8, 9);
    run(50);
    wr(0, 1);
    run(20);
    wr(0, 33);
    run(80);
    tag = "R8";
    run(10);
    stop = 1; run(5);
    stop = 0; run(30);
    stop = 1; run(1);
    stop = 0; run(40);
    tag = "R10";
    wr(6, 12'hFFF); wr(7, 3);
    run(80);
    finish_run();
  end
endmodule